// File: doc/BRIEF.md
# Interlaced 525-Line Video Sync Generator

This block is a free-running timing source for a 525-line interlaced camera or display path. A pixel-rate clock enable, derived by halving a master clock that runs at 1560 times the line rate, steps a half-line bit counter. The wraps of that counter step a field-relative half-line counter. Horizontal drive, vertical drive, composite sync, composite blanking and an odd/even field flag are decoded from these counters and registered before they leave the block.

In interlaced mode each field holds 262.5 lines, so the even field starts in the middle of a line. Non-interlaced mode shortens each field to 262 whole lines. Every field then begins on a line boundary, and a misaligned line phase is pulled back into step at the next field wrap. Sync outputs are active low and the blanking output is active high. All widths and counts are parameters. The defaults give 390 bits per half line, 60-bit horizontal sync, 30-bit equalizing pulses, 330-bit broad pulses, a 9-line vertical sync interval and 20 lines of vertical blanking.

Top module: `eia_sync_gen`

## Requirements
- R1: While rst_ni is low the counters sit at field position 0, line bit 0. The outputs read hd_n_o=0, vd_n_o=0, csync_n_o=0, cblank_o=1, field_o=0.
- R2: The counters advance by one bit only on clock edges where pix_en_i is high. Once pix_en_i has been low for two edges, every output holds its value.
- R3: A line is 2*HALF_BITS pixel bits. hd_n_o is low for the first HSYNC_BITS bits of every line and high for the rest of it.
- R4: With interlace_i=1 a field is FRAME_LINES half lines. field_o is 0 in the odd field and 1 in the even field, and it toggles at each field boundary. The even field begins HALF_BITS bits into a line.
- R5: With interlace_i=0 a field is FRAME_LINES-1 half lines. field_o still toggles at each boundary, and every field begins at line bit 0.
- R6: vd_n_o is low for the first 2*VSYNC_LINES half lines of each field and high for the rest of the field.
- R7: The vertical sync interval is split into three equal groups of half lines. In the first and last groups csync_n_o is low for the first EQ_BITS bits of each half line. In the middle group it is low for the first BROAD_BITS bits of each half line.
- R8: Outside the vertical sync interval, csync_n_o equals hd_n_o.
- R9: cblank_o is high during the first 2*VBLANK_LINES half lines of each field. It is also high for HBLANK_BITS bits of every line, starting HFRONT_BITS bits before line bit 0, that is, at line bits 2*HALF_BITS-HFRONT_BITS and above and below HBLANK_BITS-HFRONT_BITS.
- R10: Each output shows the decode of the counter state held before the clock edge that loads it, so the outputs lag the counters by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel-rate clock enable |
| interlace_i | input | 1 | 1 selects 262.5-line fields, 0 selects 262-line fields |
| hd_n_o | output | 1 | Horizontal drive, active low |
| vd_n_o | output | 1 | Vertical drive, active low |
| csync_n_o | output | 1 | Composite sync with equalizing and broad pulses, active low |
| cblank_o | output | 1 | Composite blanking, active high |
| field_o | output | 1 | Field flag, 0 odd, 1 even |

## Verification
The assertions assume that interlace_i holds steady except near a reset or field wrap. They also assume that pix_en_i is a plain enable with no relation to the counters. Outside those assumptions the blanking and sync relations between outputs still hold. The bench keeps interlace_i fixed within each run and changes it only under reset. It drives pix_en_i high continuously, except for one stretch where it is held low and then toggled, which exercises the hold behaviour. It uses reduced parameter values so that several complete fields pass in a short run.

// File: rtl/eia_sg_pkg.sv
package eia_sg_pkg;
  typedef struct packed {
    logic hd_n;
    logic vd_n;
    logic cs_n;
    logic blank;
  } sg_out_t;

  localparam sg_out_t SG_ORIGIN = '{hd_n: 1'b0, vd_n: 1'b0, cs_n: 1'b0, blank: 1'b1};
endpackage

// File: rtl/eia_sg_bitcnt.sv
module eia_sg_bitcnt #(
  parameter int HALF_BITS = 390,
  localparam int HW = $clog2(HALF_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          realign_i,
  output logic [HW-1:0] cnt_o,
  output logic          phase_o,
  output logic          half_tick_o
);
  localparam logic [HW-1:0] LAST = HW'(HALF_BITS - 1);

  assign half_tick_o = en_i && (cnt_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      phase_o <= 1'b0;
    end else if (en_i) begin
      if (cnt_o == LAST) begin
        cnt_o   <= '0;
        // realign forces the next field onto a line start
        phase_o <= realign_i ? 1'b0 : ~phase_o;
      end else begin
        cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eia_sg_fieldcnt.sv
module eia_sg_fieldcnt #(
  parameter int FRAME_LINES = 525,
  localparam int FW = $clog2(FRAME_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          half_tick_i,
  input  logic          interlace_i,
  output logic [FW-1:0] hl_o,
  output logic          field_o,
  output logic          wrap_o
);
  localparam logic [FW-1:0] LAST_IL = FW'(FRAME_LINES - 1);
  localparam logic [FW-1:0] LAST_NI = FW'(FRAME_LINES - 2);

  logic [FW-1:0] last;
  assign last   = interlace_i ? LAST_IL : LAST_NI;
  assign wrap_o = half_tick_i && (hl_o >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hl_o    <= '0;
      field_o <= 1'b0;
    end else if (half_tick_i) begin
      if (hl_o >= last) begin
        hl_o    <= '0;
        field_o <= ~field_o;
      end else begin
        hl_o <= hl_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eia_sg_decode.sv
module eia_sg_decode
  import eia_sg_pkg::*;
#(
  parameter int HALF_BITS    = 390,
  parameter int HSYNC_BITS   = 60,
  parameter int EQ_BITS      = 30,
  parameter int BROAD_BITS   = 330,
  parameter int HBLANK_BITS  = 132,
  parameter int HFRONT_BITS  = 12,
  parameter int FRAME_LINES  = 525,
  parameter int VSYNC_LINES  = 9,
  parameter int VBLANK_LINES = 20,
  localparam int HW = $clog2(HALF_BITS),
  localparam int LW = $clog2(2 * HALF_BITS),
  localparam int FW = $clog2(FRAME_LINES)
) (
  input  logic [HW-1:0] cnt_i,
  input  logic          phase_i,
  input  logic [FW-1:0] hl_i,
  output sg_out_t       out_o
);
  localparam int VS_HL = 2 * VSYNC_LINES;
  localparam int VS_GRP = VS_HL / 3;
  localparam logic [HW-1:0] HS_C    = HW'(HSYNC_BITS);
  localparam logic [HW-1:0] EQ_C    = HW'(EQ_BITS);
  localparam logic [HW-1:0] BR_C    = HW'(BROAD_BITS);
  localparam logic [LW-1:0] HALF_C  = LW'(HALF_BITS);
  localparam logic [LW-1:0] HB_LO_C = LW'(HBLANK_BITS - HFRONT_BITS);
  localparam logic [LW-1:0] HB_HI_C = LW'(2 * HALF_BITS - HFRONT_BITS);
  localparam logic [FW-1:0] VS_C    = FW'(VS_HL);
  localparam logic [FW-1:0] G1_C    = FW'(VS_GRP);
  localparam logic [FW-1:0] G2_C    = FW'(2 * VS_GRP);
  localparam logic [FW-1:0] VB_C    = FW'(2 * VBLANK_LINES);

  logic [LW-1:0] lbit;
  logic hd_act, in_vs, broad, cs_act, hblank, vblank;

  always_comb begin
    lbit   = phase_i ? (HALF_C + LW'(cnt_i)) : LW'(cnt_i);
    hd_act = !phase_i && (cnt_i < HS_C);
    in_vs  = hl_i < VS_C;
    broad  = (hl_i >= G1_C) && (hl_i < G2_C);
    if (in_vs) cs_act = broad ? (cnt_i < BR_C) : (cnt_i < EQ_C);
    else       cs_act = hd_act;
    hblank = (lbit < HB_LO_C) || (lbit >= HB_HI_C);
    vblank = hl_i < VB_C;
    out_o.hd_n  = !hd_act;
    out_o.vd_n  = !in_vs;
    out_o.cs_n  = !cs_act;
    out_o.blank = hblank || vblank;
  end
endmodule

// File: rtl/eia_sync_gen.sv
module eia_sync_gen
  import eia_sg_pkg::*;
#(
  parameter int HALF_BITS    = 390,
  parameter int HSYNC_BITS   = 60,
  parameter int EQ_BITS      = 30,
  parameter int BROAD_BITS   = 330,
  parameter int HBLANK_BITS  = 132,
  parameter int HFRONT_BITS  = 12,
  parameter int FRAME_LINES  = 525,
  parameter int VSYNC_LINES  = 9,
  parameter int VBLANK_LINES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pix_en_i,
  input  logic interlace_i,
  output logic hd_n_o,
  output logic vd_n_o,
  output logic csync_n_o,
  output logic cblank_o,
  output logic field_o
);
  localparam int HW = $clog2(HALF_BITS);
  localparam int FW = $clog2(FRAME_LINES);

  logic [HW-1:0] half_bit;
  logic          line_phase, half_tick, field_wrap, field_q;
  logic [FW-1:0] field_hl;
  sg_out_t       dec, out_q;

  eia_sg_bitcnt #(.HALF_BITS(HALF_BITS)) u_bitcnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (pix_en_i),
    .realign_i  (field_wrap && !interlace_i),
    .cnt_o      (half_bit),
    .phase_o    (line_phase),
    .half_tick_o(half_tick)
  );

  eia_sg_fieldcnt #(.FRAME_LINES(FRAME_LINES)) u_fieldcnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .half_tick_i(half_tick),
    .interlace_i(interlace_i),
    .hl_o       (field_hl),
    .field_o    (field_q),
    .wrap_o     (field_wrap)
  );

  eia_sg_decode #(
    .HALF_BITS   (HALF_BITS),
    .HSYNC_BITS  (HSYNC_BITS),
    .EQ_BITS     (EQ_BITS),
    .BROAD_BITS  (BROAD_BITS),
    .HBLANK_BITS (HBLANK_BITS),
    .HFRONT_BITS (HFRONT_BITS),
    .FRAME_LINES (FRAME_LINES),
    .VSYNC_LINES (VSYNC_LINES),
    .VBLANK_LINES(VBLANK_LINES)
  ) u_decode (
    .cnt_i  (half_bit),
    .phase_i(line_phase),
    .hl_i   (field_hl),
    .out_o  (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= SG_ORIGIN;
      field_o <= 1'b0;
    end else begin
      out_q   <= dec;
      field_o <= field_q;
    end
  end

  assign hd_n_o    = out_q.hd_n;
  assign vd_n_o    = out_q.vd_n;
  assign csync_n_o = out_q.cs_n;
  assign cblank_o  = out_q.blank;
endmodule

// File: rtl/eia_sync_gen_chk.sv
module eia_sync_gen_chk #(
  parameter int HALF_BITS = 390,
  localparam int HW = $clog2(HALF_BITS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pix_en_i,
  input logic          hd_n_o,
  input logic          vd_n_o,
  input logic          csync_n_o,
  input logic          cblank_o,
  input logic          field_o,
  input logic [HW-1:0] half_bit
);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!pix_en_i) && !pix_en_i) |=> $stable({hd_n_o, vd_n_o, csync_n_o, cblank_o, field_o}));

  assert_bit_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_bit < HW'(HALF_BITS));

  assert_field_at_vd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_o != $past(field_o)) |-> !vd_n_o);

  assert_vd_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vd_n_o) |-> (field_o != $past(field_o)));

  assert_csync_hd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vd_n_o |-> (csync_n_o == hd_n_o));

  assert_vd_blank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vd_n_o |-> cblank_o);

  assert_hd_blank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hd_n_o |-> cblank_o);
endmodule

bind eia_sync_gen eia_sync_gen_chk #(.HALF_BITS(HALF_BITS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pix_en_i (pix_en_i),
  .hd_n_o   (hd_n_o),
  .vd_n_o   (vd_n_o),
  .csync_n_o(csync_n_o),
  .cblank_o (cblank_o),
  .field_o  (field_o),
  .half_bit (half_bit)
);

// File: tb/eia_sync_gen_test.sv
`timescale 1ns/1ps
module eia_sync_gen_test;
  localparam int HB = 20, HS = 4, EQ = 2, BR = 17, HBL = 8, HFP = 2;
  localparam int FL = 15, VSL = 3, VBL = 5;
  localparam int NTBL = 15;
  localparam int TBL_P [NTBL] = '{0, 2, 45, 58, 81, 120, 142, 203, 210, 238, 299, 300, 302, 440, 600};
  // {hd_n, vd_n, cs_n, blank, field}
  localparam logic [4:0] TBL_E [NTBL] = '{5'b00010, 5'b00110, 5'b10010, 5'b10110, 5'b00010,
    5'b01010, 5'b11110, 5'b01010, 5'b11100, 5'b11110, 5'b11100, 5'b10011, 5'b10111,
    5'b01011, 5'b00010};

  logic clk_i = 1'b0, rst_ni = 1'b0, pix_en_i = 1'b0, interlace_i = 1'b1;
  logic hd_n_o, vd_n_o, csync_n_o, cblank_o, field_o;
  int errors = 0, checks = 0, st = 0, oidx = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  eia_sync_gen #(
    .HALF_BITS(HB), .HSYNC_BITS(HS), .EQ_BITS(EQ), .BROAD_BITS(BR), .HBLANK_BITS(HBL),
    .HFRONT_BITS(HFP), .FRAME_LINES(FL), .VSYNC_LINES(VSL), .VBLANK_LINES(VBL)
  ) uut (.*);

  function automatic logic [4:0] model(int p, bit il);
    int lf = il ? FL * HB : (FL - 1) * HB;
    int fp = p % lf, fh = fp / HB, hc = fp % HB, b = p % (2 * HB);
    logic hd = b < HS, vs = fh < 2 * VSL, cs, bl;
    if (vs) cs = (fh >= (2 * VSL) / 3 && fh < 2 * ((2 * VSL) / 3)) ? (hc < BR) : (hc < EQ);
    else cs = hd;
    bl = (fh < 2 * VBL) || (b < HBL - HFP) || (b >= 2 * HB - HFP);
    return {~hd, ~vs, ~cs, bl, 1'((p / lf) % 2)};
  endfunction

  task automatic chk(string req, logic act, logic exp, int p);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at bit %0d: actual=%b expected=%b", req, p, act, exp);
    end
  endtask

  task automatic chk_vec(logic [4:0] exp, int p, bit il, string tag);
    int fh = (p % (il ? FL * HB : (FL - 1) * HB)) / HB;
    chk(tag != "" ? tag : "R3 hd",    hd_n_o,    exp[4], p);
    chk(tag != "" ? tag : "R6 vd",    vd_n_o,    exp[3], p);
    chk(tag != "" ? tag : (fh < 2 * VSL ? "R7 csync" : "R8 csync"), csync_n_o, exp[2], p);
    chk(tag != "" ? tag : "R9 blank", cblank_o,  exp[1], p);
    chk(tag != "" ? tag : (il ? "R4 field" : "R5 field"), field_o, exp[0], p);
  endtask

  // one clock; outputs then show the state held before the edge (R10)
  task automatic step(bit en);
    pix_en_i = en;
    @(posedge clk_i);
    oidx = st;
    if (en) st++;
    @(negedge clk_i);
  endtask

  task automatic do_reset(bit il);
    rst_ni = 1'b0;
    interlace_i = il;
    pix_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk_vec(5'b00010, 0, il, "R1 reset");
    rst_ni = 1'b1;
    st = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    // interlaced sweep across two fields plus a frame wrap, table points checked too
    for (int i = 0; i < 620; i++) begin
      step(1'b1);
      chk_vec(model(oidx, 1'b1), oidx, 1'b1, "");
      for (int k = 0; k < NTBL; k++)
        if (TBL_P[k] == oidx) chk_vec(TBL_E[k], oidx, 1'b1, "R10 table");
    end
    // R2: enable held low, then toggled
    for (int i = 0; i < 12; i++) begin
      step(1'b0);
      chk_vec(model(oidx, 1'b1), oidx, 1'b1, "R2 hold");
    end
    for (int i = 0; i < 40; i++) begin
      step(1'(i % 2));
      chk_vec(model(oidx, 1'b1), oidx, 1'b1, "R2 gated");
    end
    // R5: non-interlaced fields
    do_reset(1'b0);
    for (int i = 0; i < 600; i++) begin
      step(1'b1);
      chk_vec(model(oidx, 1'b0), oidx, 1'b0, "");
      if (oidx == 280) begin
        chk("R5 field start", field_o, 1'b1, oidx);
        chk("R5 line start", hd_n_o, 1'b0, oidx);
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule